// File: doc/BRIEF.md
# Grouped Interrupt Level Controller

This block collects a set of peripheral interrupt request lines into one 32-bit status register. A companion 32-bit mask register sits beside it. From the status register the block produces a processor interrupt priority level and an autovector number. Each request line has a fixed bit position in the status word and a fixed group. The three groups map to processor levels 3, 5 and 6. Positions and groups are both given by parameter tables.

The mask is checked on each transition of a request line, not applied to a held status. When a source rises or falls and its mask bit is clear, the status bit follows the line. When the mask bit is set, the transition is dropped and the status bit keeps its old value.

Software reads and writes both registers as whole words through a one-bit register select. A status write can clear stale bits, or set bits for test.

Top module: `irq_level_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the status register, the mask register, `cpu_ipl`, `cpu_vector` and `cpu_irq` are all zero.
- R2: A rising request line whose mask bit is clear sets its status bit. The bit is visible after the first clock edge at which the line is sampled high. The default bit positions of sources 0 to 11 are 2, 3, 5, 6, 8, 9, 12, 17, 20, 21, 26 and 28.
- R3: A falling request line whose mask bit is clear clears its status bit at the first clock edge at which the line is sampled low.
- R4: A transition of a request line, rising or falling, whose mask bit is set leaves that status bit unchanged.
- R5: Sources 0 to 6 form the low group. Any of their status bits set, with no higher group active, gives level 3 and vector 27.
- R6: Source 7 forms the middle group. Its status bit set, with the high group inactive, gives level 5 and vector 29.
- R7: Sources 8 to 11 form the high group. Any of their status bits set gives level 6 and vector 30.
- R8: The level is the highest group among source-owned status bits that are set. `cpu_irq` is high exactly when the level is non-zero. Set bits at positions owned by no source give level 0.
- R9: `bus_sel` = 0 selects the status register and 1 selects the mask register. A write with `bus_wr` high stores `bus_wdata` at the clock edge. `bus_rdata` shows the selected register combinationally.
- R10: When a status write and an unmasked request transition fall in the same cycle, the transition decides its own bit. Every other bit takes the written data.
- R11: A mask write in the same cycle as a request transition does not affect that transition. The mask value held before the write is the one checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | NSRC | Peripheral request lines, level sensitive |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 status, 1 mask |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the selected register |
| cpu_ipl | output | 3 | Requested processor priority level (0, 3, 5, 6) |
| cpu_vector | output | 8 | Autovector number for the level (0, 27, 29, 30) |
| cpu_irq | output | 1 | High when a level is requested |

## Verification
Two functions can act on the same status bit in one cycle: a software write to the status word and a request line edge. The mask write and the mask check can also coincide. The bench provokes both cases by changing a request line at the same clock edge as a status or mask write. It then reads the registers back through `bus_rdata`. The edge must win for its own bit, the written data must land in every other bit, and the mask check must use the pre-write mask.

// File: rtl/irq_lvl_pkg.sv
// Package: shared group encoding and level/vector constants for the
// grouped interrupt controller. Assumes exactly three active groups.
package irq_lvl_pkg;

    typedef enum logic [1:0] {
        GRP_NONE = 2'd0,
        GRP_LO   = 2'd1,
        GRP_MID  = 2'd2,
        GRP_HI   = 2'd3
    } grp_e;

    localparam int IPL_W = 3;
    localparam int VEC_W = 8;

    localparam logic [IPL_W-1:0] IPL_LO  = 3'd3;
    localparam logic [IPL_W-1:0] IPL_MID = 3'd5;
    localparam logic [IPL_W-1:0] IPL_HI  = 3'd6;

    localparam logic [VEC_W-1:0] VEC_LO  = 8'd27;
    localparam logic [VEC_W-1:0] VEC_MID = 8'd29;
    localparam logic [VEC_W-1:0] VEC_HI  = 8'd30;

    // Map a group to its processor level.
    function automatic logic [IPL_W-1:0] grp_level(grp_e g);
        case (g)
            GRP_LO:  return IPL_LO;
            GRP_MID: return IPL_MID;
            GRP_HI:  return IPL_HI;
            default: return '0;
        endcase
    endfunction

    // Map a group to its autovector number.
    function automatic logic [VEC_W-1:0] grp_vector(grp_e g);
        case (g)
            GRP_LO:  return VEC_LO;
            GRP_MID: return VEC_MID;
            GRP_HI:  return VEC_HI;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/irq_src_event.sv
// Module: irq_src_event
// Registers each request line and turns its edges into per-bit set and
// clear pulses at the source's status position. An edge is dropped when
// the mask bit at that position (current register value) is set.
// Assumes distinct positions for all sources, each below DATA_W.
module irq_src_event #(
    parameter int DATA_W = 32,
    parameter int NSRC   = 12,
    parameter int POS_W  = 5,
    parameter logic [NSRC*POS_W-1:0] SRC_POS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_req,
    input  logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] set_vec,
    output logic [DATA_W-1:0] clr_vec
);

    logic [NSRC-1:0] req_q;

    // Remember the previous level; tracks the input during reset so no
    // edge is seen when reset is released.
    always_ff @(posedge clk) begin
        req_q <= src_req;
    end

    // Form masked set/clear pulses at each source's status position.
    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (rst_n && !mask_q[SRC_POS[i*POS_W +: POS_W]]) begin
                if (src_req[i] && !req_q[i])
                    set_vec[SRC_POS[i*POS_W +: POS_W]] = 1'b1;
                if (!src_req[i] && req_q[i])
                    clr_vec[SRC_POS[i*POS_W +: POS_W]] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_regs.sv
// Module: irq_regs
// Holds the status and mask words. Source pulses take precedence over a
// software status write on their own bit; all other bits take the write.
// Assumes set and clear never coincide on one bit (one source per bit).
module irq_regs #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_sel,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] set_vec,
    input  logic [DATA_W-1:0] clr_vec,
    output logic [DATA_W-1:0] status_q,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] bus_rdata
);

    logic [DATA_W-1:0] status_base;
    logic [DATA_W-1:0] status_d;

    // Choose software data or held value, then overlay source events.
    always_comb begin
        status_base = (bus_wr && !bus_sel) ? bus_wdata : status_q;
        status_d    = (status_base | set_vec) & ~clr_vec;
    end

    // Status register update.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    // Mask register update.
    always_ff @(posedge clk) begin
        if (!rst_n)                 mask_q <= '0;
        else if (bus_wr && bus_sel) mask_q <= bus_wdata;
    end

    // Combinational read of the selected register.
    always_comb begin
        bus_rdata = bus_sel ? mask_q : status_q;
    end

endmodule

// File: rtl/irq_prio_encode.sv
// Module: irq_prio_encode
// Reduces source-owned status bits to a group hit vector and picks the
// highest group. Bits owned by no source are ignored.
module irq_prio_encode
    import irq_lvl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NSRC   = 12,
    parameter int POS_W  = 5,
    parameter logic [NSRC*POS_W-1:0] SRC_POS = '0,
    parameter logic [NSRC*2-1:0]     SRC_GRP = '0
) (
    input  logic [DATA_W-1:0] status_q,
    output logic [IPL_W-1:0]  cpu_ipl,
    output logic [VEC_W-1:0]  cpu_vector,
    output logic              cpu_irq
);

    logic [2:0] hit;    // [0] low, [1] mid, [2] high
    grp_e       top_grp;

    // Gather which groups have at least one set status bit.
    always_comb begin
        hit = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (status_q[SRC_POS[i*POS_W +: POS_W]]) begin
                case (grp_e'(SRC_GRP[i*2 +: 2]))
                    GRP_LO:  hit[0] = 1'b1;
                    GRP_MID: hit[1] = 1'b1;
                    GRP_HI:  hit[2] = 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // Pick the highest active group and drive level and vector.
    always_comb begin
        if (hit[2])      top_grp = GRP_HI;
        else if (hit[1]) top_grp = GRP_MID;
        else if (hit[0]) top_grp = GRP_LO;
        else             top_grp = GRP_NONE;
        cpu_ipl    = grp_level(top_grp);
        cpu_vector = grp_vector(top_grp);
        cpu_irq    = |hit;
    end

endmodule

// File: rtl/irq_level_ctrl.sv
// Module: irq_level_ctrl (top)
// Grouped interrupt status controller: edge-sampled, mask-checked
// request lines into a status word; level and autovector out.
// Assumes request lines are synchronous to clk.
module irq_level_ctrl
    import irq_lvl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NSRC   = 12,
    parameter int POS_W  = $clog2(DATA_W),
    parameter logic [NSRC*POS_W-1:0] SRC_POS = {
        5'd28, 5'd26, 5'd21, 5'd20, 5'd17, 5'd12,
        5'd9,  5'd8,  5'd6,  5'd5,  5'd3,  5'd2},
    parameter logic [NSRC*2-1:0] SRC_GRP = {
        2'd3, 2'd3, 2'd3, 2'd3, 2'd2,
        2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_req,
    input  logic              bus_wr,
    input  logic              bus_sel,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [2:0]        cpu_ipl,
    output logic [7:0]        cpu_vector,
    output logic              cpu_irq
);

    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] clr_vec;
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] mask_q;

    irq_src_event #(
        .DATA_W(DATA_W), .NSRC(NSRC), .POS_W(POS_W), .SRC_POS(SRC_POS)
    ) u_event (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .mask_q(mask_q),
        .set_vec(set_vec), .clr_vec(clr_vec)
    );

    irq_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .set_vec(set_vec), .clr_vec(clr_vec),
        .status_q(status_q), .mask_q(mask_q), .bus_rdata(bus_rdata)
    );

    irq_prio_encode #(
        .DATA_W(DATA_W), .NSRC(NSRC), .POS_W(POS_W),
        .SRC_POS(SRC_POS), .SRC_GRP(SRC_GRP)
    ) u_enc (
        .status_q(status_q), .cpu_ipl(cpu_ipl),
        .cpu_vector(cpu_vector), .cpu_irq(cpu_irq)
    );

endmodule

// File: rtl/irq_level_ctrl_chk.sv
// Module: irq_level_ctrl_chk
// Property checker bound into irq_level_ctrl; observes ports and the
// status/mask registers.
module irq_level_ctrl_chk #(
    parameter int DATA_W = 32,
    parameter int NSRC   = 12,
    parameter int POS_W  = 5,
    parameter logic [NSRC*POS_W-1:0] SRC_POS = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC-1:0]   src_req,
    input logic              bus_wr,
    input logic              bus_sel,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] status_q,
    input logic [DATA_W-1:0] mask_q,
    input logic [2:0]        cpu_ipl,
    input logic [7:0]        cpu_vector,
    input logic              cpu_irq
);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (status_q == '0 && mask_q == '0 && !cpu_irq));

    assert_irq_iff_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == (cpu_ipl != 3'd0));

    assert_vec_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ipl == 3'd3) |-> (cpu_vector == 8'd27));

    assert_vec_mid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ipl == 3'd5) |-> (cpu_vector == 8'd29));

    assert_vec_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ipl == 3'd6) |-> (cpu_vector == 8'd30));

    assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_sel) |=> $stable(mask_q));

    assert_mask_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel) |=> (mask_q == $past(bus_wdata)));

    assert_status_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_sel && src_req == $past(src_req)) |=>
            (status_q == $past(bus_wdata)));

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam int P = int'(SRC_POS[i*POS_W +: POS_W]);

        // R10, R11: the edge decides its bit even under a same-cycle write
        assert_rise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (src_req[i] && !$past(src_req[i]) && !mask_q[P]) |=> status_q[P]);

        assert_fall_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!src_req[i] && $past(src_req[i]) && !mask_q[P]) |=> !status_q[P]);

        assert_masked_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (src_req[i] != $past(src_req[i]) && mask_q[P] && !(bus_wr && !bus_sel))
                |=> $stable(status_q[P]));
    end

endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(
    .DATA_W(DATA_W), .NSRC(NSRC), .POS_W(POS_W), .SRC_POS(SRC_POS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_wr(bus_wr),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .status_q(status_q),
    .mask_q(mask_q), .cpu_ipl(cpu_ipl), .cpu_vector(cpu_vector),
    .cpu_irq(cpu_irq)
);

// File: tb/irq_level_ctrl_bench.sv
module irq_level_ctrl_bench;

    localparam int NSRC = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NSRC-1:0] src_req = '0;
    logic        bus_wr = 1'b0;
    logic        bus_sel = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  cpu_ipl;
    logic [7:0]  cpu_vector;
    logic        cpu_irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    irq_level_ctrl u_irq_level_ctrl (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_wr(bus_wr),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_ipl(cpu_ipl), .cpu_vector(cpu_vector), .cpu_irq(cpu_irq)
    );

    // Expected bit position of a source (R2 table).
    function automatic int pos_of(int s);
        int t[NSRC] = '{2, 3, 5, 6, 8, 9, 12, 17, 20, 21, 26, 28};
        return t[s];
    endfunction

    // Expected level of a source's group (R5..R7).
    function automatic int lvl_of(int s);
        if (s < 7) return 3;
        if (s == 7) return 5;
        return 6;
    endfunction

    function automatic int vec_of(int l);
        if (l == 3) return 27;
        if (l == 5) return 29;
        if (l == 6) return 30;
        return 0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(logic sel, logic [31:0] d);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(logic sel, output logic [31:0] d);
        bus_sel = sel;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_level(string req, int l);
        check(req, {29'd0, cpu_ipl}, l);
        check(req, {24'd0, cpu_vector}, vec_of(l));
        check(req, {31'd0, cpu_irq}, (l != 0) ? 1 : 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_reg(1'b0, d); check("R1 status", d, 0);
        rd_reg(1'b1, d); check("R1 mask", d, 0);
        check_level("R1 level", 0);

        // R2/R3/R4/R5/R6/R7 per-source sweep
        for (int s = 0; s < NSRC; s++) begin
            logic [31:0] b;
            b = 32'd1 << pos_of(s);
            // unmasked rise and fall
            src_req[s] = 1'b1; tick();
            rd_reg(1'b0, d); check("R2 rise sets", d, b);
            check_level("R5/R6/R7 group level", lvl_of(s));
            src_req[s] = 1'b0; tick();
            rd_reg(1'b0, d); check("R3 fall clears", d, 0);
            check_level("R8 idle level", 0);
            // masked rise is dropped
            wr_reg(1'b1, b);
            src_req[s] = 1'b1; tick();
            rd_reg(1'b0, d); check("R4 masked rise", d, 0);
            check_level("R4 masked level", 0);
            // unmask, fall with clear mask: bit stays 0; rise sets
            wr_reg(1'b1, 0);
            src_req[s] = 1'b0; tick();
            src_req[s] = 1'b1; tick();
            rd_reg(1'b0, d); check("R2 rise after unmask", d, b);
            // masked fall keeps bit set
            wr_reg(1'b1, b);
            src_req[s] = 1'b0; tick();
            rd_reg(1'b0, d); check("R4 masked fall", d, b);
            wr_reg(1'b1, 0);
            wr_reg(1'b0, 0);
        end

        // R8 priority sweep over group combinations
        for (int c = 0; c < 8; c++) begin
            int l;
            src_req[0] = c[0]; src_req[7] = c[1]; src_req[8] = c[2];
            tick();
            l = c[2] ? 6 : c[1] ? 5 : c[0] ? 3 : 0;
            check_level("R8 highest group", l);
            src_req = '0; tick();
        end
        // R8 multiple low-group sources, then one high on top
        src_req[1] = 1'b1; src_req[6] = 1'b1; tick();
        check_level("R8 two low sources", 3);
        src_req[11] = 1'b1; tick();
        check_level("R8 high over low", 6);
        src_req = '0; tick();

        // R8/R9 bits owned by no source
        wr_reg(1'b0, 32'h8000_0013);
        rd_reg(1'b0, d); check("R9 status write", d, 32'h8000_0013);
        check_level("R8 unowned bits", 0);
        wr_reg(1'b0, 32'h0002_0000);
        check_level("R8 sw-set mid bit", 5);
        wr_reg(1'b1, 32'hA5A5_5A5A);
        rd_reg(1'b1, d); check("R9 mask write", d, 32'hA5A5_5A5A);
        rd_reg(1'b0, d); check("R9 status kept", d, 32'h0002_0000);
        wr_reg(1'b1, 0);
        wr_reg(1'b0, 0);

        // R10 status write colliding with source edges
        src_req[0] = 1'b1;
        wr_reg(1'b0, 32'h0000_0001);
        rd_reg(1'b0, d); check("R10 rise vs write", d, 32'h0000_0005);
        src_req[0] = 1'b0;
        wr_reg(1'b0, 32'hFFFF_FFFF);
        rd_reg(1'b0, d); check("R10 fall vs write", d, 32'hFFFF_FFFB);
        wr_reg(1'b0, 0);

        // R11 mask write in the same cycle as an edge
        src_req[1] = 1'b1;
        wr_reg(1'b1, 32'h0000_0008);
        rd_reg(1'b0, d); check("R11 old mask used on rise", d, 32'h0000_0008);
        rd_reg(1'b1, d); check("R11 mask stored", d, 32'h0000_0008);
        wr_reg(1'b1, 0);
        src_req[1] = 1'b0;
        wr_reg(1'b1, 32'h0000_0008);
        rd_reg(1'b0, d); check("R11 old mask used on fall", d, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule